// File: doc/BRIEF.md
# Memory Pattern Write-and-Verify Engine

This block exercises the user-side port of a memory controller. A single start pulse makes it write a generated pattern over an aligned address window. It then reads the same window back and compares every returned word with a value it regenerates on the fly. The expected value depends only on the word's address, so the block never keeps a copy of what it wrote.

The block drives three channels. The command channel carries a valid/ready handshake, an address and a read/write flag. The write data channel carries a byte mask. The read data channel carries a valid strobe. Each command moves one burst of `BURST_LEN` device beats. A user word carries `2 × CLK_RATIO` beats, so a command transfers `WPC = BURST_LEN / (2 × CLK_RATIO)` words. Word `k` of the command at address `A` belongs to word address `A + k × 2 × CLK_RATIO`.

The first mismatch sets a sticky error flag. It also stores the word address, the returned data and the expected data. These stay in place until software-independent logic pulses `clear_err`. A one-cycle `done` pulse marks the end of the check pass.

Top module: `mem_pattern_checker`

## Requirements
- R1: After `start`, write commands (`cmd_write` = 1) go out one per burst, from the aligned first address upward in steps of `BURST_LEN`. Each write command is followed by `WPC` data words. The word for word address `a` has bit `i` equal to bit `i mod ADDR_W` of `a XOR SEED`.
- R2: On every write data word, `wmask` is all zeros. A mask bit of 1 would suppress its byte, so every byte is written.
- R3: `cmd_valid` with `cmd_write` = 1 is driven only while `wdata_ready` is high.
- R4: The low four bits of `WIN_START` and `WIN_END` are ignored. The first command address is `WIN_START` with bits [3:0] cleared. The last command address is (`WIN_END` with bits [3:0] cleared) + 16 − `BURST_LEN`.
- R5: After all writes, read commands (`cmd_write` = 0) go to the same addresses in ascending order. No more than `OUTST` read bursts are ever outstanding.
- R6: Each returned word is compared with the pattern for its word address, and responses are matched in order. On a mismatch, `err` rises and `err_addr`, `err_rdata` and `err_exp` capture the word address, the returned data and the expected data.
- R7: While `err` is high, later mismatches leave the captured values unchanged.
- R8: A `clear_err` pulse drops `err` and zeroes the three capture outputs. A mismatch in the same cycle is captured afresh.
- R9: `done` is high for exactly one cycle after the last word of the window has been checked. `busy` is low from that cycle on.
- R10: A `start` pulse while `busy` is high is ignored.
- R11: After reset, `busy`, `done`, `cmd_valid`, `wdata_valid` and `err` are low, and the capture outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse to begin a write-then-verify pass |
| clear_err | input | 1 | Pulse to clear the sticky error and its captures |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle pulse at the end of the check pass |
| cmd_valid | output | 1 | Command valid |
| cmd_ready | input | 1 | Command accepted by the controller |
| cmd_write | output | 1 | 1 = write burst, 0 = read burst |
| cmd_addr | output | ADDR_W | Burst start address |
| wdata_valid | output | 1 | Write data word valid |
| wdata_ready | input | 1 | Controller can take write data |
| wdata | output | DATA_W | Write data word |
| wmask | output | MASK_W | Byte mask, 1 = suppress byte (always 0) |
| rdata_valid | input | 1 | Returned read word valid |
| rdata | input | DATA_W | Returned read word |
| err | output | 1 | Sticky mismatch flag |
| err_addr | output | ADDR_W | Word address of the first mismatch |
| err_rdata | output | DATA_W | Data returned at the first mismatch |
| err_exp | output | DATA_W | Data expected at the first mismatch |

## Verification
The bound checker watches several rules on every cycle:
- the write mask stays inactive;
- write commands appear only while write data is ready;
- read addresses rise strictly;
- burst addresses keep their alignment;
- a captured error always holds differing data and expected values, and stays frozen until cleared;
- a clear without a coinciding response empties the capture;
- `done` lasts one cycle while idle.

Only the bench's scenarios can show the rest:
- the exact address sequence and the window bounds derived from unaligned parameters;
- the generated data contents;
- that the outstanding-read limit holds under slow responses;
- that the first of two corrupted words is the one reported;
- that a start pulse mid-pass has no effect.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WR_CMD,
        PH_WR_DATA,
        PH_RD_CMD,
        PH_RD_DRAIN
    } phase_e;

    // window boundaries are aligned to this many low address bits
    localparam int unsigned ALIGN_BITS = 4;

endpackage

// File: rtl/mpc_pattern.sv
// Address-derived data pattern: bit i of the word is bit (i mod ADDR_W)
// of (addr XOR SEED).
module mpc_pattern #(
    parameter int unsigned          ADDR_W = 16,
    parameter int unsigned          DATA_W = 32,
    parameter logic [ADDR_W-1:0]    SEED   = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] word
);

    logic [ADDR_W-1:0] mixed;

    assign mixed = addr ^ SEED;

    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign word[i] = mixed[i % ADDR_W];
        end
    endgenerate

endmodule

// File: rtl/mpc_addr_fifo.sv
// Holds burst addresses of read commands that have not fully returned.
module mpc_addr_fifo #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic              pop,
    output logic [ADDR_W-1:0] head,
    output logic              full,
    output logic              empty
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t          st_d, st_q;
    logic [ADDR_W-1:0] slot_q [DEPTH];
    logic              do_push, do_pop;

    assign full    = (st_q.cnt == CNT_W'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = slot_q[st_q.rd];

    always_comb begin
        st_d = st_q;
        if (do_push) begin
            st_d.wr = (st_q.wr == PTR_LAST) ? '0 : st_q.wr + 1'b1;
        end
        if (do_pop) begin
            st_d.rd = (st_q.rd == PTR_LAST) ? '0 : st_q.rd + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            slot_q[st_q.wr] <= push_addr;
        end
    end

endmodule

// File: rtl/mpc_sequencer.sv
// Walks the window twice: write bursts with their data, then read bursts.
module mpc_sequencer
    import mpc_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 16,
    parameter int unsigned       BURST_LEN  = 8,
    parameter int unsigned       WPC        = 2,
    parameter int unsigned       WORD_STEP  = 4,
    parameter logic [ADDR_W-1:0] FIRST_ADDR = '0,
    parameter logic [ADDR_W-1:0] LAST_ADDR  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cmd_ready,
    input  logic              wdata_ready,
    input  logic              fifo_full,
    input  logic              fifo_empty,
    output logic              cmd_valid,
    output logic              cmd_write,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              wdata_valid,
    output logic [ADDR_W-1:0] wr_word_addr,
    output logic              rd_push,
    output logic              busy,
    output logic              done
);

    localparam int unsigned       IDX_W    = (WPC > 1) ? $clog2(WPC) : 1;
    localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(WPC - 1);
    localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(BURST_LEN);
    localparam logic [ADDR_W-1:0] WSTEP    = ADDR_W'(WORD_STEP);

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] addr;
        logic [IDX_W-1:0]  idx;
        logic              done;
    } seq_st_t;

    localparam seq_st_t SEQ_RST = '{phase: PH_IDLE, addr: '0, idx: '0, done: 1'b0};

    seq_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.done   = 1'b0;
        cmd_valid   = 1'b0;
        cmd_write   = 1'b0;
        wdata_valid = 1'b0;
        rd_push     = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase = PH_WR_CMD;
                    st_d.addr  = FIRST_ADDR;
                    st_d.idx   = '0;
                end
            end
            PH_WR_CMD: begin
                cmd_write = 1'b1;
                cmd_valid = wdata_ready;
                if (wdata_ready && cmd_ready) begin
                    st_d.phase = PH_WR_DATA;
                    st_d.idx   = '0;
                end
            end
            PH_WR_DATA: begin
                wdata_valid = 1'b1;
                if (wdata_ready) begin
                    if (st_q.idx == IDX_LAST) begin
                        st_d.idx = '0;
                        if (st_q.addr == LAST_ADDR) begin
                            st_d.phase = PH_RD_CMD;
                            st_d.addr  = FIRST_ADDR;
                        end else begin
                            st_d.phase = PH_WR_CMD;
                            st_d.addr  = st_q.addr + STEP;
                        end
                    end else begin
                        st_d.idx = st_q.idx + 1'b1;
                    end
                end
            end
            PH_RD_CMD: begin
                cmd_valid = !fifo_full;
                if (!fifo_full && cmd_ready) begin
                    rd_push = 1'b1;
                    if (st_q.addr == LAST_ADDR) begin
                        st_d.phase = PH_RD_DRAIN;
                    end else begin
                        st_d.addr = st_q.addr + STEP;
                    end
                end
            end
            PH_RD_DRAIN: begin
                if (fifo_empty) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end
            end
            default: st_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SEQ_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_addr     = st_q.addr;
    assign wr_word_addr = st_q.addr + ADDR_W'(st_q.idx) * WSTEP;
    assign busy         = (st_q.phase != PH_IDLE);
    assign done         = st_q.done;

endmodule

// File: rtl/mpc_check_core.sv
// Compares returned words with the regenerated pattern and keeps the
// first failure until cleared.
module mpc_check_core #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned WPC       = 2,
    parameter int unsigned WORD_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_err,
    input  logic              rdata_valid,
    input  logic [DATA_W-1:0] rdata,
    input  logic [ADDR_W-1:0] head_addr,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] exp_word,
    output logic              pop,
    output logic [ADDR_W-1:0] chk_word_addr,
    output logic              err,
    output logic [ADDR_W-1:0] err_addr,
    output logic [DATA_W-1:0] err_rdata,
    output logic [DATA_W-1:0] err_exp
);

    localparam int unsigned       IDX_W    = (WPC > 1) ? $clog2(WPC) : 1;
    localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(WPC - 1);
    localparam logic [ADDR_W-1:0] WSTEP    = ADDR_W'(WORD_STEP);

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic              err;
        logic [ADDR_W-1:0] eaddr;
        logic [DATA_W-1:0] edata;
        logic [DATA_W-1:0] eexp;
    } chk_st_t;

    chk_st_t st_d, st_q;
    logic    beat;
    logic    mismatch;

    assign chk_word_addr = head_addr + ADDR_W'(st_q.idx) * WSTEP;
    assign beat          = rdata_valid && !fifo_empty;
    assign mismatch      = beat && (rdata != exp_word);

    always_comb begin
        st_d = st_q;
        pop  = 1'b0;
        if (clear_err) begin
            st_d.err   = 1'b0;
            st_d.eaddr = '0;
            st_d.edata = '0;
            st_d.eexp  = '0;
        end
        if (mismatch && (!st_q.err || clear_err)) begin
            st_d.err   = 1'b1;
            st_d.eaddr = chk_word_addr;
            st_d.edata = rdata;
            st_d.eexp  = exp_word;
        end
        if (beat) begin
            if (st_q.idx == IDX_LAST) begin
                st_d.idx = '0;
                pop      = 1'b1;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err       = st_q.err;
    assign err_addr  = st_q.eaddr;
    assign err_rdata = st_q.edata;
    assign err_exp   = st_q.eexp;

endmodule

// File: rtl/mem_pattern_checker.sv
module mem_pattern_checker
    import mpc_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 16,
    parameter int unsigned       CLK_RATIO = 2,
    parameter int unsigned       DQ_W      = 8,
    parameter int unsigned       BURST_LEN = 8,
    parameter int unsigned       OUTST     = 2,
    parameter logic [ADDR_W-1:0] WIN_START = 16'h0103,
    parameter logic [ADDR_W-1:0] WIN_END   = 16'h011F,
    parameter logic [ADDR_W-1:0] SEED      = 16'hA5C3,
    localparam int unsigned      DATA_W    = 2 * CLK_RATIO * DQ_W,
    localparam int unsigned      MASK_W    = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              clear_err,
    output logic              busy,
    output logic              done,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic              cmd_write,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              wdata_valid,
    input  logic              wdata_ready,
    output logic [DATA_W-1:0] wdata,
    output logic [MASK_W-1:0] wmask,
    input  logic              rdata_valid,
    input  logic [DATA_W-1:0] rdata,
    output logic              err,
    output logic [ADDR_W-1:0] err_addr,
    output logic [DATA_W-1:0] err_rdata,
    output logic [DATA_W-1:0] err_exp
);

    localparam int unsigned       WORD_STEP  = 2 * CLK_RATIO;
    localparam int unsigned       WPC        = (BURST_LEN / WORD_STEP > 0) ? BURST_LEN / WORD_STEP : 1;
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'((1 << ALIGN_BITS) - 1);
    localparam logic [ADDR_W-1:0] FIRST_ADDR = WIN_START & ALIGN_MASK;
    localparam logic [ADDR_W-1:0] LAST_ADDR  = (WIN_END & ALIGN_MASK)
                                             + ADDR_W'(1 << ALIGN_BITS) - ADDR_W'(BURST_LEN);

    logic              fifo_full, fifo_empty, rd_push, rd_pop;
    logic [ADDR_W-1:0] head_addr;
    logic [ADDR_W-1:0] wr_word_addr, chk_word_addr;
    logic [DATA_W-1:0] exp_word;

    mpc_sequencer #(
        .ADDR_W    (ADDR_W),
        .BURST_LEN (BURST_LEN),
        .WPC       (WPC),
        .WORD_STEP (WORD_STEP),
        .FIRST_ADDR(FIRST_ADDR),
        .LAST_ADDR (LAST_ADDR)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .cmd_ready   (cmd_ready),
        .wdata_ready (wdata_ready),
        .fifo_full   (fifo_full),
        .fifo_empty  (fifo_empty),
        .cmd_valid   (cmd_valid),
        .cmd_write   (cmd_write),
        .cmd_addr    (cmd_addr),
        .wdata_valid (wdata_valid),
        .wr_word_addr(wr_word_addr),
        .rd_push     (rd_push),
        .busy        (busy),
        .done        (done)
    );

    mpc_pattern #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .SEED  (SEED)
    ) wr_pat_i (
        .addr(wr_word_addr),
        .word(wdata)
    );

    mpc_addr_fifo #(
        .ADDR_W(ADDR_W),
        .DEPTH (OUTST)
    ) pend_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (rd_push),
        .push_addr(cmd_addr),
        .pop      (rd_pop),
        .head     (head_addr),
        .full     (fifo_full),
        .empty    (fifo_empty)
    );

    mpc_pattern #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .SEED  (SEED)
    ) chk_pat_i (
        .addr(chk_word_addr),
        .word(exp_word)
    );

    mpc_check_core #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .WPC      (WPC),
        .WORD_STEP(WORD_STEP)
    ) chk_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_err    (clear_err),
        .rdata_valid  (rdata_valid),
        .rdata        (rdata),
        .head_addr    (head_addr),
        .fifo_empty   (fifo_empty),
        .exp_word     (exp_word),
        .pop          (rd_pop),
        .chk_word_addr(chk_word_addr),
        .err          (err),
        .err_addr     (err_addr),
        .err_rdata    (err_rdata),
        .err_exp      (err_exp)
    );

    assign wmask = '0;

endmodule

// File: rtl/mem_pattern_checker_sva.sv
module mem_pattern_checker_sva #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned MASK_W    = 4,
    parameter int unsigned BURST_LEN = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear_err,
    input logic              busy,
    input logic              done,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              cmd_write,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              wdata_valid,
    input logic              wdata_ready,
    input logic [MASK_W-1:0] wmask,
    input logic              rdata_valid,
    input logic              err,
    input logic [ADDR_W-1:0] err_addr,
    input logic [DATA_W-1:0] err_rdata,
    input logic [DATA_W-1:0] err_exp
);

    localparam logic [ADDR_W-1:0] BURST_MASK = ADDR_W'(BURST_LEN - 1);

    logic [ADDR_W-1:0] last_rd_q;
    logic              have_rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_rd_q <= '0;
            have_rd_q <= 1'b0;
        end else if (cmd_valid && cmd_ready) begin
            if (cmd_write) begin
                have_rd_q <= 1'b0;
            end else begin
                have_rd_q <= 1'b1;
                last_rd_q <= cmd_addr;
            end
        end
    end

    // R2
    wmask_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdata_valid |-> (wmask == '0));

    // R3
    wr_cmd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_write) |-> wdata_ready);

    // R4
    burst_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ((cmd_addr & BURST_MASK) == '0));

    // R5
    rd_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && !cmd_write && have_rd_q) |-> (cmd_addr > last_rd_q));

    // R6
    err_differs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (err_rdata != err_exp));

    // R7
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clear_err) |=> (err && $stable(err_addr) && $stable(err_rdata) && $stable(err_exp)));

    // R8
    clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_err && !rdata_valid) |=> (!err && err_addr == '0));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

bind mem_pattern_checker mem_pattern_checker_sva #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .MASK_W   (MASK_W),
    .BURST_LEN(BURST_LEN)
) sva_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_err  (clear_err),
    .busy       (busy),
    .done       (done),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_write  (cmd_write),
    .cmd_addr   (cmd_addr),
    .wdata_valid(wdata_valid),
    .wdata_ready(wdata_ready),
    .wmask      (wmask),
    .rdata_valid(rdata_valid),
    .err        (err),
    .err_addr   (err_addr),
    .err_rdata  (err_rdata),
    .err_exp    (err_exp)
);

// File: tb/mem_pattern_checker_tb_top.sv
`timescale 1ns/1ps
module mem_pattern_checker_tb_top;

    localparam logic [15:0] SEED       = 16'hA5C3;
    localparam logic [15:0] EXP_FIRST  = 16'h0100;
    localparam logic [15:0] EXP_LAST   = 16'h0118;
    localparam int          NCMD       = 4;
    localparam int          OUTST      = 2;

    typedef struct packed {
        logic        cen;
        logic [15:0] ca;
        logic [15:0] ca2;
        logic [31:0] flip;
        logic [3:0]  cst;
        logic [3:0]  wst;
        logic [3:0]  lat;
    } scen_t;

    localparam int NSCEN = 5;
    localparam scen_t SCEN [NSCEN] = '{
        '{1'b0, 16'h0000, 16'h0000, 32'h0000_0000, 4'd0, 4'd0, 4'd2},
        '{1'b1, 16'h0104, 16'h0104, 32'h0000_0100, 4'd3, 4'd0, 4'd1},
        '{1'b1, 16'h011C, 16'h011C, 32'h8000_0000, 4'd0, 4'd2, 4'd5},
        '{1'b1, 16'h0100, 16'h0100, 32'h0000_0001, 4'd2, 4'd3, 4'd3},
        '{1'b1, 16'h0108, 16'h0114, 32'hFFFF_FFFF, 4'd0, 4'd0, 4'd4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        clear_err = 1'b0;
    logic        busy, done;
    logic        cmd_valid, cmd_write;
    logic        cmd_ready = 1'b1;
    logic [15:0] cmd_addr;
    logic        wdata_valid;
    logic        wdata_ready = 1'b1;
    logic [31:0] wdata;
    logic [3:0]  wmask;
    logic        rdata_valid = 1'b0;
    logic [31:0] rdata = '0;
    logic        err;
    logic [15:0] err_addr;
    logic [31:0] err_rdata, err_exp;

    always #5 clk = ~clk;

    mem_pattern_checker #(
        .WIN_START(16'h0103),
        .WIN_END  (16'h011F),
        .SEED     (SEED),
        .OUTST    (OUTST)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .clear_err(clear_err),
        .busy(busy), .done(done),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
        .wdata_valid(wdata_valid), .wdata_ready(wdata_ready), .wdata(wdata), .wmask(wmask),
        .rdata_valid(rdata_valid), .rdata(rdata),
        .err(err), .err_addr(err_addr), .err_rdata(err_rdata), .err_exp(err_exp)
    );

    int checks = 0;
    int fails  = 0;

    // model and trace state
    scen_t       cur;
    logic [31:0] mem [256];
    logic [31:0] rq_data [$];
    int          rq_due [$];
    int          cyc = 0;
    logic [15:0] exp_wr, exp_rd, cur_wa, first_wa, last_wa;
    int          widx, wr_cnt, rd_cnt, wr_order_err, rd_order_err, wdata_err;
    int          mask_err, gate_err, done_cnt, outst, max_out, rbeat;

    function automatic logic [31:0] pat(input logic [15:0] a);
        logic [15:0] m;
        logic [31:0] r;
        m = a ^ SEED;
        for (int i = 0; i < 32; i++) r[i] = m[i % 16];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic trace_reset();
        exp_wr = EXP_FIRST; exp_rd = EXP_FIRST; widx = 0;
        wr_cnt = 0; rd_cnt = 0; wr_order_err = 0; rd_order_err = 0; wdata_err = 0;
        mask_err = 0; gate_err = 0; done_cnt = 0; outst = 0; max_out = 0; rbeat = 0;
        first_wa = 16'hFFFF; last_wa = 16'h0000;
    endtask

    // behavioural memory with adjustable stalls, latency and corruption
    initial begin
        cur = SCEN[0];
        trace_reset();
        forever begin
            @(negedge clk);
            cyc++;
            cmd_ready   = (cur.cst == 0) ? 1'b1 : ((cyc % int'(cur.cst)) != 0);
            wdata_ready = (cur.wst == 0) ? 1'b1 : ((cyc % int'(cur.wst)) != 0);
            if (!rst_n) begin
                rq_data.delete(); rq_due.delete();
            end
            if (rq_data.size() > 0 && rq_due[0] <= cyc) begin
                rdata_valid = 1'b1;
                rdata       = rq_data.pop_front();
                void'(rq_due.pop_front());
                rbeat++;
                if (rbeat == 2) begin rbeat = 0; outst--; end
            end else begin
                rdata_valid = 1'b0;
            end
            #1;
            if (done) done_cnt++;
            if (cmd_valid && cmd_write && !wdata_ready) gate_err++;
            if (cmd_valid && cmd_ready) begin
                if (cmd_write) begin
                    if (cmd_addr != exp_wr) wr_order_err++;
                    if (wr_cnt == 0) first_wa = cmd_addr;
                    last_wa = cmd_addr;
                    exp_wr = exp_wr + 16'd8;
                    wr_cnt++;
                    cur_wa = cmd_addr;
                    widx = 0;
                end else begin
                    if (cmd_addr != exp_rd) rd_order_err++;
                    exp_rd = exp_rd + 16'd8;
                    rd_cnt++;
                    outst++;
                    if (outst > max_out) max_out = outst;
                    for (int w = 0; w < 2; w++) begin
                        logic [15:0] wa;
                        logic [31:0] d;
                        wa = cmd_addr + 16'(4 * w);
                        d  = mem[wa[7:0]];
                        if (cur.cen && (wa == cur.ca || wa == cur.ca2)) d = d ^ cur.flip;
                        rq_data.push_back(d);
                        rq_due.push_back(cyc + int'(cur.lat) + w);
                    end
                end
            end
            if (wdata_valid && wdata_ready) begin
                logic [15:0] wa;
                wa = cur_wa + 16'(4 * widx);
                if (wdata != pat(wa)) wdata_err++;
                if (wmask != 4'h0) mask_err++;
                mem[wa[7:0]] = wdata;
                widx++;
            end
        end
    end

    task automatic run_scen(input scen_t s, input bit do_clear);
        int n;
        cur = s;
        trace_reset();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (6) @(negedge clk);
        start = 1'b1;                       // R10: second pulse while busy
        @(negedge clk); start = 1'b0;
        n = 0;
        while (!done && n < 4000) begin @(negedge clk); n++; end
        #2;
        chk(done == 1'b1, "R9 done seen", done, 1);
        @(negedge clk); #2;
        chk(done == 1'b0 && busy == 1'b0, "R9 done one cycle, idle", {done, busy}, 0);
        repeat (10) @(negedge clk);
        #2;
        chk(done_cnt == 1 && wr_cnt == NCMD, "R10 single pass", {done_cnt, wr_cnt}, {1, NCMD});
        chk(wr_order_err == 0 && wdata_err == 0, "R1 write sequence and data", {wr_order_err, wdata_err}, 0);
        chk(mask_err == 0, "R2 wmask zero", mask_err, 0);
        chk(gate_err == 0, "R3 write cmd gated by wdata_ready", gate_err, 0);
        chk(first_wa == EXP_FIRST && last_wa == EXP_LAST, "R4 window bounds", {first_wa, last_wa}, {EXP_FIRST, EXP_LAST});
        chk(rd_cnt == NCMD && rd_order_err == 0 && max_out <= OUTST, "R5 read order and limit",
            {rd_cnt, rd_order_err, max_out}, {NCMD, 0, OUTST});
        chk(err == s.cen, "R6 err flag", err, s.cen);
        if (s.cen) begin
            chk(err_addr == s.ca, "R7 R6 err_addr first failure", err_addr, s.ca);
            chk(err_rdata == (pat(s.ca) ^ s.flip), "R6 err_rdata", err_rdata, pat(s.ca) ^ s.flip);
            chk(err_exp == pat(s.ca), "R6 err_exp", err_exp, pat(s.ca));
        end
        if (do_clear) begin
            clear_err = 1'b1;
            @(negedge clk); clear_err = 1'b0;
            #2;
            chk(err == 1'b0 && err_addr == '0 && err_rdata == '0 && err_exp == '0, "R8 clear",
                {err, err_addr}, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #2;
        // R11: state straight out of reset
        chk(!busy && !done && !cmd_valid && !wdata_valid && !err && err_addr == '0,
            "R11 reset outputs", {busy, done, cmd_valid, wdata_valid, err}, 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int k = 0; k < NSCEN; k++) begin
            run_scen(SCEN[k], 1'b1);
        end

        // directed: error left set, then reset must clear it (R11)
        run_scen(SCEN[2], 1'b0);
        chk(err == 1'b1, "R7 err still held before reset", err, 1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); #2;
        chk(!err && err_addr == '0 && err_rdata == '0 && !busy, "R11 reset clears capture",
            {err, err_addr, busy}, 0);
        @(negedge clk); rst_n = 1'b1;

        // directed: reset in the middle of a pass (R11)
        cur = SCEN[0];
        trace_reset();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk); #2;
        chk(!busy && !cmd_valid && !wdata_valid && !done, "R11 reset mid-pass",
            {busy, cmd_valid, wdata_valid, done}, 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);
        run_scen(SCEN[1], 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R9 actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule